// File: doc/BRIEF.md
# Trip-threshold programming command detector

This block listens on an already synchronized two-wire serial bus (clock and data lines) for the one write frame that adjusts a supply-monitor trip threshold. It finds START and STOP conditions and shifts in bytes most significant bit first on each rising clock edge. It pulls the data line low on the ninth clock to acknowledge each byte that fits the expected frame. An accepted frame has four bytes: the device byte A0h, an address high byte 00h, an address low byte, and a data byte 00h. The address low byte selects the operation. 01h sets the threshold to the present supply level. 03h returns the threshold to its native low level.

A request is raised only on the STOP that closes a complete frame, and only if two qualifiers are both high at that STOP: the write-enable latch and the flag that reports a programming voltage on the write-protect pin. The request is a single-cycle pulse on one of two outputs. A busy flag then stays high until the programming sequence completes. While busy is high, further frames raise no request. The analog threshold storage and the high-voltage sensing are outside this block.

Top module: `trip_prog_detector`

## Requirements
- R1: After reset, `ack_o`, `set_req_o`, `clr_req_o` and `busy_o` are all low.
- R2: Bytes are taken MSB first on rising `scl_i`. `ack_o` is high (the data line is pulled low) during the ninth clock of each byte that matches the frame in sequence: A0h, then 00h, then 01h or 03h, then 00h.
- R3: A byte that does not match its position in the frame is not acknowledged. The frame is then discarded and no request follows its STOP.
- R4: A complete frame with address low byte 01h, followed by STOP, produces a one-cycle pulse on `set_req_o`.
- R5: A complete frame with address low byte 03h, followed by STOP, produces a one-cycle pulse on `clr_req_o`.
- R6: `set_req_o` and `clr_req_o` are never high together, and neither stays high for two cycles in a row.
- R7: No request is issued unless `wel_i` and `hv_wp_i` are both high at the STOP.
- R8: A repeated START inside a frame discards it. The next frame is accepted only after a STOP.
- R9: A fifth byte sent after the data byte is not acknowledged, and the frame gives no request.
- R10: `busy_o` goes high together with a request. It stays high until `done_i` is seen high while `hv_wp_i` is low. No request is issued while `busy_o` is high.
- R11: A request appears only after STOP, never at the end of the last data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line (wired level) |
| wel_i | input | 1 | Write-enable latch is set |
| hv_wp_i | input | 1 | Programming voltage is present on write-protect pin |
| done_i | input | 1 | Threshold programming has completed |
| ack_o | output | 1 | High to pull the data line low (acknowledge) |
| set_req_o | output | 1 | One-cycle request: set threshold to the present supply level |
| clr_req_o | output | 1 | One-cycle request: reset threshold to its native level |
| busy_o | output | 1 | Programming in progress |

## Verification
The hardest case to reach from the ports is a repeated START inside a frame whose bytes are otherwise all correct. The byte receiver starts over cleanly, so the whole frame looks valid, and only the frame tracker remembers that the earlier frame was cut off. The bench sends two good bytes, then a START with no STOP before it, then a complete valid frame and a STOP. It expects no acknowledge and no request. A following STOP-delimited frame must then succeed. The busy-hold case is also driven on purpose: `done_i` is raised while `hv_wp_i` is still high, and `busy_o` is expected to stay high.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_DATA, ST_FULL, ST_BAD
  } frame_st_e;

  typedef enum logic {OP_SET, OP_CLR} trip_op_e;
endpackage

// File: rtl/tpd_line_cond.sv
module tpd_line_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/tpd_byte_rx.sv
module tpd_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic              ack_ok_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              ack_o
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);
  localparam logic [CW-1:0] ACK_HOLD = CW'(BYTE_W + 1);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              active_q, done_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        cnt_q    <= '0;
        active_q <= 1'b1;
        ack_q    <= 1'b0;
      end else if (stop_i) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
        ack_q    <= 1'b0;
      end else if (active_q) begin
        if (rise_i && cnt_q < ACK_SLOT) begin
          sh_q   <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q  <= cnt_q + 1'b1;
          done_q <= (cnt_q == LAST_BIT);
        end else if (fall_i && cnt_q == ACK_SLOT) begin
          ack_q <= ack_ok_i;
          cnt_q <= ACK_HOLD;
        end else if (fall_i && cnt_q == ACK_HOLD) begin
          ack_q <= 1'b0;
          cnt_q <= '0;
        end
      end
    end
  end

  assign byte_o      = sh_q;
  assign byte_done_o = done_q;
  assign ack_o       = ack_q;
endmodule

// File: rtl/tpd_frame_fsm.sv
module tpd_frame_fsm
  import tpd_pkg::*;
#(
  parameter int              BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] DEV_BYTE = 8'hA0,
  parameter logic [BYTE_W-1:0] AHI_BYTE = 8'h00,
  parameter logic [BYTE_W-1:0] SET_LO   = 8'h01,
  parameter logic [BYTE_W-1:0] CLR_LO   = 8'h03,
  parameter logic [BYTE_W-1:0] DAT_BYTE = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              wel_i,
  input  logic              hv_wp_i,
  input  logic              done_i,
  output logic              ack_ok_o,
  output logic              set_req_o,
  output logic              clr_req_o,
  output logic              busy_o
);
  frame_st_e state_q, nxt;
  trip_op_e  op_q, nop;
  logic      acc, ack_ok_q, set_q, clr_q, busy_q, fire;

  always_comb begin
    nxt = ST_BAD;
    nop = op_q;
    acc = 1'b0;
    unique case (state_q)
      ST_DEV:  if (byte_i == DEV_BYTE) begin nxt = ST_AHI; acc = 1'b1; end
      ST_AHI:  if (byte_i == AHI_BYTE) begin nxt = ST_ALO; acc = 1'b1; end
      ST_ALO: begin
        if (byte_i == SET_LO) begin
          nxt = ST_DATA; nop = OP_SET; acc = 1'b1;
        end else if (byte_i == CLR_LO) begin
          nxt = ST_DATA; nop = OP_CLR; acc = 1'b1;
        end
      end
      ST_DATA: if (byte_i == DAT_BYTE) begin nxt = ST_FULL; acc = 1'b1; end
      default: nxt = ST_BAD;
    endcase
  end

  // programming only starts at the STOP that closes a full frame
  assign fire = stop_i && state_q == ST_FULL && wel_i && hv_wp_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_SET;
      ack_ok_q <= 1'b0;
      set_q    <= 1'b0;
      clr_q    <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      set_q <= fire && op_q == OP_SET;
      clr_q <= fire && op_q == OP_CLR;
      if (fire)                      busy_q <= 1'b1;
      else if (done_i && !hv_wp_i)   busy_q <= 1'b0;
      if (start_i) begin
        state_q  <= (state_q == ST_IDLE) ? ST_DEV : ST_BAD;
        ack_ok_q <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        ack_ok_q <= 1'b0;
      end else if (byte_done_i) begin
        state_q  <= nxt;
        op_q     <= nop;
        ack_ok_q <= acc;
      end
    end
  end

  assign ack_ok_o  = ack_ok_q;
  assign set_req_o = set_q;
  assign clr_req_o = clr_q;
  assign busy_o    = busy_q;
endmodule

// File: rtl/trip_prog_detector.sv
module trip_prog_detector #(
  parameter int BYTE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wel_i,
  input  logic hv_wp_i,
  input  logic done_i,
  output logic ack_o,
  output logic set_req_o,
  output logic clr_req_o,
  output logic busy_o
);
  logic start, stop, rise, fall, byte_done, ack_ok;
  logic [BYTE_W-1:0] rx_byte;

  tpd_line_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_o(start), .stop_o(stop), .rise_o(rise), .fall_o(fall)
  );

  tpd_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i, .rst_ni,
    .start_i(start), .stop_i(stop), .rise_i(rise), .fall_i(fall),
    .sda_i, .ack_ok_i(ack_ok),
    .byte_o(rx_byte), .byte_done_o(byte_done), .ack_o
  );

  tpd_frame_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .stop_i(stop),
    .byte_done_i(byte_done), .byte_i(rx_byte),
    .wel_i, .hv_wp_i, .done_i,
    .ack_ok_o(ack_ok), .set_req_o, .clr_req_o, .busy_o
  );
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic wel_i,
  input logic hv_wp_i,
  input logic done_i,
  input logic ack_o,
  input logic set_req_o,
  input logic clr_req_o,
  input logic busy_o
);
  assert_req_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_req_o && clr_req_o));

  assert_set_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_req_o |=> !set_req_o);

  assert_clr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_o |=> !clr_req_o);

  assert_req_qualified_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_req_o || clr_req_o) |-> $past(wel_i && hv_wp_i && !busy_o));

  assert_req_on_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_req_o || clr_req_o) |-> $past(scl_i && sda_i));

  assert_busy_with_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_req_o || clr_req_o) |-> busy_o);

  assert_busy_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_i && !hv_wp_i));

  assert_ack_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> !scl_i);
endmodule

bind trip_prog_detector tpd_checker u_tpd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
  .wel_i(wel_i), .hv_wp_i(hv_wp_i), .done_i(done_i), .ack_o(ack_o),
  .set_req_o(set_req_o), .clr_req_o(clr_req_o), .busy_o(busy_o)
);

// File: tb/trip_prog_detector_bench.sv
`timescale 1ns/1ps
module trip_prog_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic wel = 1'b1, hv = 1'b1, done = 1'b0;
  logic ack, set_req, clr_req, busy, sda_line;
  int   checks = 0, errors = 0;
  int   n_set = 0, n_clr = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_drv & ~ack;

  trip_prog_detector u_trip_prog_detector (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .wel_i(wel), .hv_wp_i(hv), .done_i(done),
    .ack_o(ack), .set_req_o(set_req), .clr_req_o(clr_req), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (set_req) n_set++;
    if (clr_req) n_clr++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_clk(3);
    scl = 1'b1;     wait_clk(3);
    sda_drv = 1'b0; wait_clk(3);
    scl = 1'b0;     wait_clk(3);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_clk(3);
    scl = 1'b1;     wait_clk(3);
    sda_drv = 1'b1; wait_clk(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_clk(3);
      scl = 1'b1;     wait_clk(3);
      scl = 1'b0;     wait_clk(3);
    end
    sda_drv = 1'b1; wait_clk(3);
    scl = 1'b1;     wait_clk(3);
    a = ack;
    scl = 1'b0;     wait_clk(4);
  endtask

  // sends four bytes, returns ack bits packed MSB = first byte
  task automatic send_frame(input logic [7:0] lo, input logic [7:0] dat, output logic [3:0] acks);
    logic a;
    bus_start();
    send_byte(8'hA0, a); acks[3] = a;
    send_byte(8'h00, a); acks[2] = a;
    send_byte(lo,    a); acks[1] = a;
    send_byte(dat,   a); acks[0] = a;
  endtask

  task automatic finish_busy();
    done = 1'b1; hv = 1'b0; wait_clk(3);
    done = 1'b0; hv = 1'b1; wait_clk(2);
  endtask

  task automatic t_reset();
    chk(ack == 0 && set_req == 0 && clr_req == 0 && busy == 0, "R1 reset outputs",
        {ack, set_req, clr_req, busy}, 0);
  endtask

  task automatic t_set();
    logic [3:0] acks;
    int s0 = n_set, c0 = n_clr;
    send_frame(8'h01, 8'h00, acks);
    chk(acks == 4'hF, "R2 all bytes acked", acks, 15);
    chk(n_set == s0, "R11 no request before STOP", n_set - s0, 0);
    bus_stop();
    chk(n_set - s0 == 1, "R4 single set pulse", n_set - s0, 1);
    chk(n_clr == c0, "R6 no clear with set", n_clr - c0, 0);
    chk(busy == 1, "R10 busy after request", busy, 1);
    // second valid frame while busy
    send_frame(8'h03, 8'h00, acks);
    bus_stop();
    chk(n_clr == c0 && n_set - s0 == 1, "R10 no request while busy", n_clr - c0, 0);
    done = 1'b1; wait_clk(3);
    chk(busy == 1, "R10 busy held while WP high", busy, 1);
    done = 1'b0; hv = 1'b0; wait_clk(3);
    chk(busy == 1, "R10 busy held without done", busy, 1);
    done = 1'b1; wait_clk(3);
    chk(busy == 0, "R10 busy cleared", busy, 0);
    done = 1'b0; hv = 1'b1; wait_clk(2);
  endtask

  task automatic t_clr();
    logic [3:0] acks;
    int s0 = n_set, c0 = n_clr;
    send_frame(8'h03, 8'h00, acks);
    bus_stop();
    chk(acks == 4'hF, "R2 clear frame acked", acks, 15);
    chk(n_clr - c0 == 1 && n_set == s0, "R5 single clear pulse", n_clr - c0, 1);
    finish_busy();
  endtask

  task automatic t_qual();
    logic [3:0] acks;
    int s0 = n_set;
    wel = 1'b0;
    send_frame(8'h01, 8'h00, acks);
    bus_stop();
    chk(n_set == s0, "R7 no request without write enable", n_set - s0, 0);
    wel = 1'b1; hv = 1'b0;
    send_frame(8'h01, 8'h00, acks);
    bus_stop();
    chk(n_set == s0 && busy == 0, "R7 no request without WP voltage", n_set - s0, 0);
    hv = 1'b1; wait_clk(2);
  endtask

  task automatic t_bad_dev();
    logic a;
    int s0 = n_set;
    bus_start();
    send_byte(8'hA2, a);
    chk(a == 0, "R3 wrong device byte not acked", a, 0);
    send_byte(8'h00, a);
    chk(a == 0, "R3 later byte not acked", a, 0);
    send_byte(8'h01, a);
    send_byte(8'h00, a);
    bus_stop();
    chk(n_set == s0, "R3 no request after bad device", n_set - s0, 0);
  endtask

  task automatic t_bad_lo_data();
    logic [3:0] acks;
    int s0 = n_set, c0 = n_clr;
    send_frame(8'h02, 8'h00, acks);
    bus_stop();
    chk(acks == 4'hC, "R3 bad address low nacked", acks, 12);
    send_frame(8'h01, 8'h01, acks);
    bus_stop();
    chk(acks == 4'hE, "R3 bad data nacked", acks, 14);
    chk(n_set == s0 && n_clr == c0, "R3 no request", n_set - s0, 0);
  endtask

  task automatic t_extra();
    logic [3:0] acks;
    logic a;
    int s0 = n_set;
    send_frame(8'h01, 8'h00, acks);
    send_byte(8'h00, a);
    bus_stop();
    chk(acks == 4'hF && a == 0, "R9 extra byte nacked", a, 0);
    chk(n_set == s0, "R9 no request after extra byte", n_set - s0, 0);
  endtask

  task automatic t_restart();
    logic [3:0] acks;
    logic a;
    int s0 = n_set;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'h00, a);
    send_frame(8'h01, 8'h00, acks);
    chk(acks == 4'h0, "R8 frame after repeated START nacked", acks, 0);
    bus_stop();
    chk(n_set == s0, "R8 no request after repeated START", n_set - s0, 0);
    send_frame(8'h01, 8'h00, acks);
    bus_stop();
    chk(n_set - s0 == 1, "R8 recovers after STOP", n_set - s0, 1);
    finish_busy();
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_set();
    t_clr();
    t_qual();
    t_bad_dev();
    t_bad_lo_data();
    t_extra();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule